// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two active-low processor inputs: a normal interrupt request and a fast interrupt request. Line 0 belongs to the fast output. Every other line passes through a per-line enable and a per-line trigger stage. That stage is level or edge, with selectable polarity on lines marked external. It then enters a priority arbiter with eight levels. Any line may also be forced onto the fast output, and it then leaves the arbiter.

Software reads the vector register to obtain the 32-bit vector programmed for the winning line. In normal operation, that read also acknowledges the interrupt. The winner's level is pushed onto an in-service stack, and its edge latch is cleared. Writing the end-of-service register pops the stack. A source interrupts a running handler only when its level is strictly above the level on top of the stack. A debug protect mode makes vector reads free of side effects. A write to the vector register then performs the acknowledge.

Top module: `vpic_top`

## Requirements
- R1: Line 0, when enabled and active, drives `nfiq_o` low and never takes part in normal arbitration or drives `nirq_o`.
- R2: A line whose bit is set in the force mask (word 0x42, bit n = line n) drives `nfiq_o` low when enabled and active, and is removed from normal arbitration.
- R3: Each line contributes only while its enable bit is set (word 0x40 write-ones-to-set and read, word 0x41 write-ones-to-clear). Control word 0x43 bit 1 (global mask) holds both `nirq_o` and `nfiq_o` high.
- R4: Among enabled, active, non-forced lines 1..31, the winner is the one with the highest level (config bits [2:0], 7 highest). On equal levels, the lowest line number wins.
- R5: `nirq_o` is low exactly when a winner exists, the global mask is off, and either the stack is empty or the winner's level is strictly greater than the level on top of the stack.
- R6: In normal mode (control bit 0 clear), reading the vector register (word 0x45) while `nirq_o` would be low returns the winner's vector (words 0x00+n). It also pushes the winner's level and clears that line's edge latch, so `nirq_o` goes high until a higher level arrives.
- R7: A write to word 0x46 pops one level from a non-empty stack, and `nirq_o` is then re-evaluated against the new top.
- R8: A vector read when no line qualifies returns the spurious vector (word 0x44) and changes no state.
- R9: With control bit 0 set (protect), vector reads return the same value but push nothing and clear nothing. A write to word 0x45 performs the acknowledge instead.
- R10: Config bit 4 selects edge mode. An edge-mode line latches a rising activity edge and stays pending until acknowledged. A level-mode line is pending while active.
- R11: On external lines (by default 30 and 31), config bit 5 = 0 selects falling-edge/low-level activity. Bit 5 = 1 selects rising/high. The inputs pass through a two-flop synchronizer before edge compare.
- R12: Read data appears on `bus_rdata_o` the cycle after the read strobe. Config words (0x20+n) read back as {pol, edge, 0, level} in bits [5:0]. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 7 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_src_i | input | 32 | Interrupt request lines |
| nirq_o | output | 1 | Normal interrupt, active low |
| nfiq_o | output | 1 | Fast interrupt, active low |

## Verification
The arbiter is tried with three simultaneous lines, two of them sharing the top level, which separates level ordering from the index tie-break. Nesting is tried with a line of equal level arriving during service and then a strictly higher one, which separates strict from non-strict preemption. Edge pulses are compared against held levels, and falling against rising activity on the external lines, to tell the latch from the direct path. Acknowledge by read is compared with protect-mode reads followed by a commit write, which shows which path moves the stack.

// File: rtl/vpic_pkg.sv
`timescale 1ns/1ps
package vpic_pkg;
    localparam int PRIO_W  = 3;
    localparam int NUM_LVL = 8;

    typedef struct packed {
        logic              pol;
        logic              edge_md;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam logic [6:0] A_EN_SET = 7'h40;
    localparam logic [6:0] A_EN_CLR = 7'h41;
    localparam logic [6:0] A_FORCE  = 7'h42;
    localparam logic [6:0] A_CTRL   = 7'h43;
    localparam logic [6:0] A_SPUR   = 7'h44;
    localparam logic [6:0] A_IVR    = 7'h45;
    localparam logic [6:0] A_EOC    = 7'h46;
endpackage

// File: rtl/vpic_src_cond.sv
`timescale 1ns/1ps
// Per-line trigger stage: optional synchronizer, polarity, edge latch.
module vpic_src_cond #(
    parameter bit EXTERNAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    input  logic edge_md_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic latch;
    } cond_t;

    cond_t st_d, st_q;
    logic  samp, act, rise;

    always_comb begin
        samp = EXTERNAL ? st_q.s2 : st_q.s1;
        act  = (EXTERNAL && !pol_i) ? ~samp : samp;
        rise = act & ~st_q.prev;
        st_d       = st_q;
        st_d.s1    = raw_i;
        st_d.s2    = st_q.s1;
        st_d.prev  = act;
        st_d.latch = edge_md_i & ((st_q.latch & ~clr_i) | rise);
        pend_o     = edge_md_i ? st_q.latch : act;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{s1: 1'b0, s2: 1'b0, prev: 1'b1, latch: 1'b0};
        else         st_q <= st_d;
    end

    // R6: an acknowledge with no fresh edge leaves the latch empty
    assert_ack_clears_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !rise) |=> !st_q.latch);
endmodule

// File: rtl/vpic_arbiter.sv
`timescale 1ns/1ps
// Highest level wins; strict compare keeps the lowest index on ties.
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int SRC_IW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]              req_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    output logic                         valid_o,
    output logic [SRC_IW-1:0]            idx_o,
    output logic [PRIO_W-1:0]            prio_o
);
    logic              found;
    logic [SRC_IW-1:0] best_idx;
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (!found || prio_i[i] > best_prio)) begin
                found     = 1'b1;
                best_idx  = SRC_IW'(i);
                best_prio = prio_i[i];
            end
        end
        valid_o = found;
        idx_o   = best_idx;
        prio_o  = best_prio;
    end
endmodule

// File: rtl/vpic_top.sv
`timescale 1ns/1ps
// NSRC must be a power of two no larger than 32 (fixed word map).
module vpic_top
    import vpic_pkg::*;
#(
    parameter int              NSRC     = 32,
    parameter int              DATA_W   = 32,
    parameter logic [NSRC-1:0] EXT_MASK = 32'hC000_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [6:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NSRC-1:0]   irq_src_i,
    output logic              nirq_o,
    output logic              nfiq_o
);
    localparam int SRC_IW = $clog2(NSRC);
    localparam int LVL_IW = $clog2(NUM_LVL);
    localparam int SP_W   = $clog2(NUM_LVL + 1);
    localparam logic [NSRC-1:0] NRM_MASK = {{(NSRC-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [NSRC-1:0][DATA_W-1:0]   vec;
        src_cfg_t [NSRC-1:0]           cfg;
        logic [NSRC-1:0]               en;
        logic [NSRC-1:0]               frc;
        logic                          prot;
        logic                          gmask;
        logic [DATA_W-1:0]             spur;
        logic [DATA_W-1:0]             rdata;
        logic [NUM_LVL-1:0][PRIO_W-1:0] stk;
        logic [SP_W-1:0]               sp;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NSRC-1:0]             pend, live, nrm_req, clr;
    logic [NSRC-1:0][PRIO_W-1:0] prio_vec;
    logic                        win_valid, beats, in_srv, fiq_req, ack;
    logic [SRC_IW-1:0]           win_idx;
    logic [PRIO_W-1:0]           win_prio, cur_lvl;
    logic [SRC_IW-1:0]           a_idx;
    logic [DATA_W-1:0]           ivr_val, rd_val;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vpic_src_cond #(.EXTERNAL(EXT_MASK[g])) u_cond (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .raw_i    (irq_src_i[g]),
            .edge_md_i(st_q.cfg[g].edge_md),
            .pol_i    (st_q.cfg[g].pol),
            .clr_i    (clr[g]),
            .pend_o   (pend[g])
        );
        assign prio_vec[g] = st_q.cfg[g].prio;
    end

    assign live    = pend & st_q.en;
    assign nrm_req = live & ~st_q.frc & NRM_MASK;
    assign fiq_req = live[0] | (|(live & st_q.frc));

    vpic_arbiter #(.NSRC(NSRC)) u_arb (
        .req_i  (nrm_req),
        .prio_i (prio_vec),
        .valid_o(win_valid),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    always_comb begin
        in_srv  = (st_q.sp != '0);
        cur_lvl = st_q.stk[LVL_IW'(st_q.sp - 1'b1)];
        beats   = win_valid && (!in_srv || win_prio > cur_lvl)
                  && (st_q.sp < SP_W'(NUM_LVL));
        nirq_o  = ~(beats & ~st_q.gmask);
        nfiq_o  = ~(fiq_req & ~st_q.gmask);
        ivr_val = beats ? st_q.vec[win_idx] : st_q.spur;
        ack     = beats && bus_addr_i == A_IVR &&
                  ((bus_rd_i && !st_q.prot) || (bus_wr_i && st_q.prot));
        a_idx   = bus_addr_i[SRC_IW-1:0];

        rd_val = '0;
        case (bus_addr_i[6:5])
            2'b00: rd_val = st_q.vec[a_idx];
            2'b01: rd_val = DATA_W'({st_q.cfg[a_idx].pol, st_q.cfg[a_idx].edge_md,
                                     1'b0, st_q.cfg[a_idx].prio});
            default: begin
                case (bus_addr_i)
                    A_EN_SET: rd_val = DATA_W'(st_q.en);
                    A_FORCE:  rd_val = DATA_W'(st_q.frc);
                    A_CTRL:   rd_val = DATA_W'({st_q.gmask, st_q.prot});
                    A_SPUR:   rd_val = st_q.spur;
                    A_IVR:    rd_val = ivr_val;
                    default:  rd_val = '0;
                endcase
            end
        endcase

        st_d = st_q;
        clr  = '0;
        if (bus_rd_i) st_d.rdata = rd_val;
        if (ack) begin
            st_d.stk[st_q.sp[LVL_IW-1:0]] = win_prio;
            st_d.sp      = st_q.sp + 1'b1;
            clr[win_idx] = 1'b1;
        end else if (bus_wr_i && bus_addr_i == A_EOC && in_srv) begin
            st_d.sp = st_q.sp - 1'b1;
        end
        if (bus_wr_i) begin
            case (bus_addr_i[6:5])
                2'b00: st_d.vec[a_idx] = bus_wdata_i;
                2'b01: st_d.cfg[a_idx] = '{pol: bus_wdata_i[5], edge_md: bus_wdata_i[4],
                                           prio: bus_wdata_i[PRIO_W-1:0]};
                default: begin
                    case (bus_addr_i)
                        A_EN_SET: st_d.en  = st_q.en | bus_wdata_i[NSRC-1:0];
                        A_EN_CLR: st_d.en  = st_q.en & ~bus_wdata_i[NSRC-1:0];
                        A_FORCE:  st_d.frc = bus_wdata_i[NSRC-1:0];
                        A_CTRL: begin
                            st_d.prot  = bus_wdata_i[0];
                            st_d.gmask = bus_wdata_i[1];
                        end
                        A_SPUR:   st_d.spur = bus_wdata_i;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;

    // R5: stack never deeper than the number of levels
    assert_sp_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.sp <= SP_W'(NUM_LVL));
    // R5: levels on the stack strictly increase toward the top
    assert_nest_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sp >= SP_W'(2)) |->
        (st_q.stk[LVL_IW'(st_q.sp - 1'b1)] > st_q.stk[LVL_IW'(st_q.sp - SP_W'(2))]));
    // R3: global mask silences both outputs
    assert_gmask_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.gmask |-> (nirq_o && nfiq_o));
    // R1: line 0 never wins normal arbitration
    assert_no_line0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid |-> (win_idx != '0));
    // R4: the winner is a live, non-forced line
    assert_winner_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid |-> (live[win_idx] && !st_q.frc[win_idx]));
    // R6: acknowledging read pushes one level
    assert_ack_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == A_IVR && !st_q.prot && beats) |=>
        (st_q.sp == $past(st_q.sp) + 1'b1));
    // R9: protected read moves nothing
    assert_protect_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !bus_wr_i && bus_addr_i == A_IVR && st_q.prot) |=>
        ($stable(st_q.sp) && $stable(st_q.stk)));
    // R7: end-of-service pops one level
    assert_eoc_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !bus_rd_i && bus_addr_i == A_EOC && st_q.sp != '0) |=>
        (st_q.sp == $past(st_q.sp) - 1'b1));
endmodule

// File: tb/vpic_top_tb_top.sv
`timescale 1ns/1ps
module vpic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        nirq, nfiq;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] v;

    localparam logic [6:0] IVR = 7'h45, EOC = 7'h46, ENS = 7'h40, ENC = 7'h41;
    localparam logic [6:0] FRC = 7'h42, CTL = 7'h43, SPR = 7'h44;

    always #2.5 clk = ~clk;

    vpic_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_src_i(src), .nirq_o(nirq), .nfiq_o(nfiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic cfg(input int n, input logic pol, input logic edg, input logic [2:0] p);
        wreg(7'h20 + 7'(n), {26'b0, pol, edg, 1'b0, p});
    endtask

    task automatic t_reset;
        check("R12 reset nirq", {31'b0, nirq}, 32'd1);
        check("R12 reset nfiq", {31'b0, nfiq}, 32'd1);
        rreg(IVR, v); check("R8 R12 reset spurious", v, 32'h0);
        for (int n = 0; n < 32; n++) wreg(7'(n), 32'h1000 + n);
        wreg(SPR, 32'hDEAD_0000);
    endtask

    task automatic t_fiq;
        wreg(ENS, 32'h1);
        src[0] = 1'b1; idle(3);
        check("R1 line0 nfiq", {31'b0, nfiq}, 32'd0);
        check("R1 line0 not nirq", {31'b0, nirq}, 32'd1);
        src[0] = 1'b0; idle(3);
        check("R1 line0 release", {31'b0, nfiq}, 32'd1);
    endtask

    task automatic t_prio;
        cfg(3, 0, 0, 3'd2); cfg(5, 0, 0, 3'd6); cfg(7, 0, 0, 3'd6);
        wreg(ENS, 32'hA8);
        src[3] = 1'b1; src[5] = 1'b1; src[7] = 1'b1; idle(3);
        check("R5 nirq low", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R4 tie lowest index", v, 32'h1005);
        check("R6 nirq high after ack", {31'b0, nirq}, 32'd1);
        wreg(EOC, 0); idle(1);
        check("R7 pop reasserts", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R4 winner again", v, 32'h1005);
        src[3] = 1'b0; src[5] = 1'b0; src[7] = 1'b0; idle(3);
        wreg(EOC, 0); idle(2);
        check("R7 empty stack idle", {31'b0, nirq}, 32'd1);
    endtask

    task automatic t_preempt;
        src[3] = 1'b1; idle(3);
        rreg(IVR, v); check("R6 vector line3", v, 32'h1003);
        cfg(9, 0, 0, 3'd2); wreg(ENS, 32'h200);
        src[9] = 1'b1; idle(3);
        check("R5 equal level no preempt", {31'b0, nirq}, 32'd1);
        cfg(10, 0, 0, 3'd4); wreg(ENS, 32'h400);
        src[10] = 1'b1; idle(3);
        check("R5 higher level preempts", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R5 nested vector", v, 32'h100A);
        src[3] = 1'b0; src[9] = 1'b0; src[10] = 1'b0; idle(3);
        wreg(EOC, 0); wreg(EOC, 0); idle(2);
        check("R7 unwound", {31'b0, nirq}, 32'd1);
    endtask

    task automatic pulse12;
        @(negedge clk); src[12] = 1'b1;
        @(negedge clk); src[12] = 1'b0;
    endtask

    task automatic t_edge;
        cfg(12, 0, 1, 3'd3); wreg(ENS, 32'h1000);
        pulse12(); idle(3);
        check("R10 edge latched", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R10 edge vector", v, 32'h100C);
        wreg(EOC, 0); idle(2);
        check("R6 latch cleared by ack", {31'b0, nirq}, 32'd1);
    endtask

    task automatic t_spur;
        rreg(IVR, v); check("R8 spurious vector", v, 32'hDEAD_0000);
        check("R8 no change", {31'b0, nirq}, 32'd1);
    endtask

    task automatic t_protect;
        wreg(CTL, 32'h1);
        pulse12(); idle(3);
        rreg(IVR, v); check("R9 protected read value", v, 32'h100C);
        check("R9 read no push", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R9 second read same", v, 32'h100C);
        wreg(IVR, 0); idle(1);
        check("R9 write commits ack", {31'b0, nirq}, 32'd1);
        wreg(EOC, 0); wreg(CTL, 32'h0); idle(2);
        check("R9 latch cleared by commit", {31'b0, nirq}, 32'd1);
    endtask

    task automatic t_force;
        wreg(FRC, 32'h4000); cfg(14, 0, 0, 3'd7); wreg(ENS, 32'h4000);
        src[14] = 1'b1; idle(3);
        check("R2 forced to nfiq", {31'b0, nfiq}, 32'd0);
        check("R2 forced not nirq", {31'b0, nirq}, 32'd1);
        src[14] = 1'b0; idle(3);
        check("R2 forced release", {31'b0, nfiq}, 32'd1);
        wreg(FRC, 32'h0);
    endtask

    task automatic t_mask;
        src[3] = 1'b1; src[0] = 1'b1; idle(3);
        check("R3 both active nirq", {31'b0, nirq}, 32'd0);
        wreg(CTL, 32'h2); idle(1);
        check("R3 gmask nirq", {31'b0, nirq}, 32'd1);
        check("R3 gmask nfiq", {31'b0, nfiq}, 32'd1);
        wreg(CTL, 32'h0); idle(1);
        check("R3 unmask", {31'b0, nirq}, 32'd0);
        wreg(ENC, 32'h8); idle(1);
        check("R3 enable clear", {31'b0, nirq}, 32'd1);
        src[3] = 1'b0; src[0] = 1'b0; idle(3);
        check("R3 nfiq idle", {31'b0, nfiq}, 32'd1);
    endtask

    task automatic t_ext;
        src[31] = 1'b1; src[30] = 1'b1; idle(5);
        cfg(31, 0, 1, 3'd5); cfg(30, 0, 0, 3'd1);
        wreg(ENS, 32'hC000_0000); idle(5);
        check("R11 idle-high no request", {31'b0, nirq}, 32'd1);
        src[31] = 1'b0; idle(5);
        check("R11 falling edge", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R11 falling vector", v, 32'h101F);
        wreg(EOC, 0); idle(2);
        check("R11 edge served", {31'b0, nirq}, 32'd1);
        src[30] = 1'b0; idle(5);
        check("R11 low level", {31'b0, nirq}, 32'd0);
        rreg(IVR, v); check("R11 low vector", v, 32'h101E);
        check("R6 level held no reassert", {31'b0, nirq}, 32'd1);
        src[30] = 1'b1; idle(5);
        wreg(EOC, 0); idle(2);
        check("R11 low released", {31'b0, nirq}, 32'd1);
    endtask

    task automatic t_readback;
        rreg(7'h3F, v); check("R12 cfg readback", v, 32'h15);
        rreg(CTL, v);   check("R12 ctrl readback", v, 32'h0);
        rreg(SPR, v);   check("R12 spurious readback", v, 32'hDEAD_0000);
        rreg(7'h07, v); check("R12 vector readback", v, 32'h1007);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset(); t_fiq(); t_prio(); t_preempt(); t_edge();
        t_spur(); t_protect(); t_force(); t_mask(); t_ext(); t_readback();
        finish_run();
    end
endmodule